// File: doc/BRIEF.md
# Triggered Event Merger and Framer

This block builds one framed event package for each trigger accept it receives. An accept arrives as a single-cycle strobe. The strobe carries a 2-bit tag that selects one of four event buffers, plus a 32-bit word of trigger bits. The tag and the bits are held together in a small queue.

For the entry at the head of the queue, the block takes exactly one fragment from every source. Each source is a 32-bit valid/ready stream fed by a link receiver FIFO. The sources are drained in index order, and each fragment ends on the word that has its end flag set. The block checks that the first word of every fragment carries the same buffer tag as the queued accept.

The package goes out on a 32-bit valid/ready port. A control flag marks the two framing words. The order is: a header, then the trigger bits, then all fragment words unchanged, then a trailer. The trailer carries the word count and an error bit. A fragment whose tag does not match is still forwarded, but the package is flagged and a sticky counter advances. The package for the next accept starts only after the trailer of the current one has been taken.

The state machine has five states:
- ST_IDLE waits for a queued accept and moves to ST_HEAD when the queue is not empty.
- ST_HEAD presents the header and moves to ST_TRIG when the sink takes it.
- ST_TRIG presents the trigger bits and moves to ST_FRAG when the sink takes them.
- ST_FRAG forwards source words. On the end word of the last source it moves to ST_TAIL.
- ST_TAIL presents the trailer. When the sink takes it, the accept is popped and the state returns to ST_IDLE.

Top module: `evt_merger`

## Requirements
- R1: The first word of each package has pkt_ctrl=1. Its bits [31:24] are 0xA5, bits [9:8] hold the accept tag, bits [7:0] hold the event number, and all other bits are 0.
- R2: The second word of each package is the accept's trigger-bits word, with pkt_ctrl=0.
- R3: After the trigger bits come the fragments in source-index order, starting at source 0. Each fragment runs up to and including its word with src_last=1. Every word is forwarded unchanged with pkt_ctrl=0.
- R4: The last word of each package has pkt_ctrl=1. Its bits [31:24] are 0x5A, bit 23 is the error bit, bits [15:0] count the fragment words of the package, and all other bits are 0.
- R5: The event number is 0 in the first package after reset. It rises by one for each completed package and wraps modulo 256.
- R6: A fragment whose first word's bits [1:0] differ from the accept tag is still forwarded. It sets the package's error bit and adds one to mis_count. mis_count saturates at its maximum value and is cleared only by reset.
- R7: While pkt_valid=1 and pkt_ready=0, pkt_valid stays 1 and pkt_data and pkt_ctrl stay unchanged. No word is dropped or duplicated.
- R8: Up to ACC_DEPTH accepts are queued. acc_busy is 1 exactly while the queue is full. A strobe given while acc_busy=1 is discarded and produces no package.
- R9: A source that runs empty in the middle of an event only delays the package. It does not set the error bit.
- R10: Packages leave in the order of their accepts. A header never appears before the previous package's trailer.
- R11: Synchronous reset empties the accept queue and returns the machine to idle, giving pkt_valid=0 and acc_busy=0. It also clears mis_count and the event number.
- R12: At most one src_ready bit is 1 in any cycle. A src_ready bit is 1 only while pkt_ready=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_stb | input | 1 | Trigger accept strobe |
| acc_tag | input | 2 | Event buffer tag of the accept |
| acc_bits | input | 32 | Trigger bits of the accept |
| acc_busy | output | 1 | Accept queue full; strobes are refused |
| src_valid | input | N_IN | Per-source word valid |
| src_data | input | 32*N_IN | Per-source words, source i in bits [32i+31:32i] |
| src_last | input | N_IN | Per-source end-of-fragment flag |
| src_ready | output | N_IN | Per-source word taken |
| pkt_valid | output | 1 | Package word valid |
| pkt_data | output | 32 | Package word |
| pkt_ctrl | output | 1 | Word is a header or a trailer |
| pkt_ready | input | 1 | Sink takes the word |
| mis_count | output | MIS_W | Saturating count of tag mismatches |

## Verification
The bench builds the block with N_IN=3 so that source ordering and the step between fragments are exercised. ACC_DEPTH=4 lets a short stall of the sink fill the queue and raise acc_busy. MIS_W=3 makes the mismatch counter saturate after seven bad fragments, which a randomized run reaches easily. Close to three hundred packages pass through, so the 8-bit event number wraps. Random gaps on the sources and random backpressure from the sink cover the wait and hold behaviour.

// File: rtl/evm_pkg.sv
package evm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_TRIG,
        ST_FRAG,
        ST_TAIL
    } evm_state_e;

    localparam int          WORD_W   = 32;
    localparam int          TAG_W    = 2;
    localparam int          EVN_W    = 8;
    localparam int          WCNT_W   = 16;
    localparam logic [7:0]  HDR_MARK = 8'hA5;
    localparam logic [7:0]  TRL_MARK = 8'h5A;

    function automatic logic [WORD_W-1:0] make_header(input logic [TAG_W-1:0] tag,
                                                      input logic [EVN_W-1:0] evn);
        return {HDR_MARK, 14'd0, tag, evn};
    endfunction

    function automatic logic [WORD_W-1:0] make_trailer(input logic err,
                                                       input logic [WCNT_W-1:0] cnt);
        return {TRL_MARK, err, 7'd0, cnt};
    endfunction

endpackage

// File: rtl/evm_fifo.sv
module evm_fifo #(
    parameter int W     = 34,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] fill;
    logic             do_push;
    logic             do_pop;

    assign empty   = (fill == '0);
    assign full    = (fill == CNT_FULL);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
            end
            unique case ({do_push, do_pop})
                2'b10:   fill <= fill + CNT_W'(1);
                2'b01:   fill <= fill - CNT_W'(1);
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/evm_sel.sv
module evm_sel #(
    parameter int N_IN  = 3,
    parameter int W     = 32,
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0]  sel,
    input  logic              en,
    input  logic              sink_ready,
    input  logic [N_IN-1:0]   src_valid,
    input  logic [N_IN*W-1:0] src_data,
    input  logic [N_IN-1:0]   src_last,
    output logic [N_IN-1:0]   src_ready,
    output logic              sel_valid,
    output logic [W-1:0]      sel_data,
    output logic              sel_last
);
    for (genvar g = 0; g < N_IN; g++) begin : g_rdy
        assign src_ready[g] = en && sink_ready && (sel == IDX_W'(g));
    end

    always_comb begin
        sel_valid = 1'b0;
        sel_data  = '0;
        sel_last  = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (sel == IDX_W'(i)) begin
                sel_valid = src_valid[i];
                sel_data  = src_data[i*W +: W];
                sel_last  = src_last[i];
            end
        end
    end

endmodule

// File: rtl/evt_merger.sv
module evt_merger
    import evm_pkg::*;
#(
    parameter int N_IN      = 3,
    parameter int ACC_DEPTH = 4,
    parameter int MIS_W     = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   acc_stb,
    input  logic [1:0]             acc_tag,
    input  logic [31:0]            acc_bits,
    output logic                   acc_busy,
    input  logic [N_IN-1:0]        src_valid,
    input  logic [32*N_IN-1:0]     src_data,
    input  logic [N_IN-1:0]        src_last,
    output logic [N_IN-1:0]        src_ready,
    output logic                   pkt_valid,
    output logic [31:0]            pkt_data,
    output logic                   pkt_ctrl,
    input  logic                   pkt_ready,
    output logic [MIS_W-1:0]       mis_count
);
    localparam int                IDX_W    = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(N_IN - 1);
    localparam int                ENT_W    = TAG_W + WORD_W;
    localparam logic [MIS_W-1:0]  MIS_MAX  = {MIS_W{1'b1}};

    evm_state_e        state;
    evm_state_e        state_nx;

    logic [ENT_W-1:0]  q_head;
    logic              q_empty;
    logic              q_full;
    logic              q_pop;
    logic [TAG_W-1:0]  q_tag;
    logic [WORD_W-1:0] q_bits;

    logic [IDX_W-1:0]  sel;
    logic              first_word;
    logic              err_flag;
    logic [WCNT_W-1:0] wcount;
    logic [EVN_W-1:0]  evn;
    logic [MIS_W-1:0]  mis_q;

    logic              sel_valid;
    logic [WORD_W-1:0] sel_data;
    logic              sel_last;
    logic              in_frag;
    logic              frag_fire;
    logic              frag_bad;

    // Accept queue: tag and trigger bits travel together
    evm_fifo #(.W(ENT_W), .DEPTH(ACC_DEPTH)) u_accq (
        .clk     (clk),
        .rst     (rst),
        .push    (acc_stb),
        .wr_data ({acc_tag, acc_bits}),
        .pop     (q_pop),
        .rd_data (q_head),
        .empty   (q_empty),
        .full    (q_full)
    );

    assign q_tag    = q_head[ENT_W-1 -: TAG_W];
    assign q_bits   = q_head[WORD_W-1:0];
    assign acc_busy = q_full;

    assign in_frag = (state == ST_FRAG);

    evm_sel #(.N_IN(N_IN), .W(WORD_W), .IDX_W(IDX_W)) u_sel (
        .sel        (sel),
        .en         (in_frag),
        .sink_ready (pkt_ready),
        .src_valid  (src_valid),
        .src_data   (src_data),
        .src_last   (src_last),
        .src_ready  (src_ready),
        .sel_valid  (sel_valid),
        .sel_data   (sel_data),
        .sel_last   (sel_last)
    );

    assign frag_fire = in_frag && sel_valid && pkt_ready;
    assign frag_bad  = first_word && (sel_data[TAG_W-1:0] != q_tag);
    assign q_pop     = (state == ST_TAIL) && pkt_ready;
    assign mis_count = mis_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (!q_empty)                state_nx = ST_HEAD;
            ST_HEAD: if (pkt_ready)               state_nx = ST_TRIG;
            ST_TRIG: if (pkt_ready)               state_nx = ST_FRAG;
            ST_FRAG: if (frag_fire && sel_last && sel == IDX_LAST)
                                                  state_nx = ST_TAIL;
            ST_TAIL: if (pkt_ready)               state_nx = ST_IDLE;
            default:                              state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pkt_valid = 1'b0;
        pkt_ctrl  = 1'b0;
        pkt_data  = '0;
        unique case (state)
            ST_IDLE: ;
            ST_HEAD: begin
                pkt_valid = 1'b1;
                pkt_ctrl  = 1'b1;
                pkt_data  = make_header(q_tag, evn);
            end
            ST_TRIG: begin
                pkt_valid = 1'b1;
                pkt_data  = q_bits;
            end
            ST_FRAG: begin
                pkt_valid = sel_valid;
                pkt_data  = sel_data;
            end
            ST_TAIL: begin
                pkt_valid = 1'b1;
                pkt_ctrl  = 1'b1;
                pkt_data  = make_trailer(err_flag, wcount);
            end
            default: ;
        endcase
    end

    // Per-event datapath and counters
    always_ff @(posedge clk) begin
        if (rst) begin
            sel        <= '0;
            first_word <= 1'b1;
            err_flag   <= 1'b0;
            wcount     <= '0;
            evn        <= '0;
            mis_q      <= '0;
        end else begin
            if (state == ST_TRIG && pkt_ready) begin
                sel        <= '0;
                first_word <= 1'b1;
                err_flag   <= 1'b0;
                wcount     <= '0;
            end
            if (frag_fire) begin
                wcount     <= wcount + WCNT_W'(1);
                first_word <= sel_last;
                if (sel_last && sel != IDX_LAST) begin
                    sel <= sel + IDX_W'(1);
                end
                if (frag_bad) begin
                    err_flag <= 1'b1;
                    if (mis_q != MIS_MAX) begin
                        mis_q <= mis_q + MIS_W'(1);
                    end
                end
            end
            if (q_pop) begin
                evn <= evn + EVN_W'(1);
            end
        end
    end

endmodule

// File: rtl/evm_merger_chk.sv
module evm_merger_chk #(
    parameter int N_IN  = 3,
    parameter int MIS_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_busy,
    input logic [N_IN-1:0]  src_ready,
    input logic             pkt_valid,
    input logic [31:0]      pkt_data,
    input logic             pkt_ctrl,
    input logic             pkt_ready,
    input logic [MIS_W-1:0] mis_count
);
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data) && $stable(pkt_ctrl)));

    // R12
    one_src_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_ready));

    // R12
    src_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (src_ready != '0) |-> pkt_ready);

    // R6
    mis_mono_chk: assert property (@(posedge clk) disable iff (rst)
        mis_count >= $past(mis_count));

    // R1
    ctrl_valid_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_ctrl |-> pkt_valid);

    // R4
    ctrl_mark_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_ctrl |-> (pkt_data[31:24] == 8'hA5 || pkt_data[31:24] == 8'h5A));

    // R11
    rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pkt_valid && !acc_busy && mis_count == '0));

endmodule

bind evt_merger evm_merger_chk #(.N_IN(N_IN), .MIS_W(MIS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_busy  (acc_busy),
    .src_ready (src_ready),
    .pkt_valid (pkt_valid),
    .pkt_data  (pkt_data),
    .pkt_ctrl  (pkt_ctrl),
    .pkt_ready (pkt_ready),
    .mis_count (mis_count)
);

// File: tb/tb_evt_merger.sv
`timescale 1ns/1ps
module tb_evt_merger;
    localparam int N_IN      = 3;
    localparam int ACC_DEPTH = 4;
    localparam int MIS_W     = 3;
    localparam int MIS_SAT   = 7;
    localparam int N_RAND    = 280;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                acc_stb = 1'b0;
    logic [1:0]          acc_tag = '0;
    logic [31:0]         acc_bits = '0;
    logic                acc_busy;
    logic [N_IN-1:0]     src_valid = '0;
    logic [32*N_IN-1:0]  src_data = '0;
    logic [N_IN-1:0]     src_last = '0;
    logic [N_IN-1:0]     src_ready;
    logic                pkt_valid;
    logic [31:0]         pkt_data;
    logic                pkt_ctrl;
    logic                pkt_ready = 1'b0;
    logic [MIS_W-1:0]    mis_count;

    evt_merger #(.N_IN(N_IN), .ACC_DEPTH(ACC_DEPTH), .MIS_W(MIS_W)) dut (
        .clk(clk), .rst(rst), .acc_stb(acc_stb), .acc_tag(acc_tag),
        .acc_bits(acc_bits), .acc_busy(acc_busy), .src_valid(src_valid),
        .src_data(src_data), .src_last(src_last), .src_ready(src_ready),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_ctrl(pkt_ctrl),
        .pkt_ready(pkt_ready), .mis_count(mis_count)
    );

    always #4 clk = ~clk;

    logic [32:0] srcq [N_IN][$];
    logic [32:0] exp_q [$];
    string       exp_req [$];
    int          nchk = 0;
    int          nerr = 0;
    int          evt_model = 0;
    int          mis_model = 0;
    int          rdy_mode = 2;   // 0 stall, 1 random, 2 always
    logic [N_IN-1:0] fired = '0;
    logic        prev_stall = 1'b0;
    logic [32:0] prev_word = '0;

    task automatic check(input bit ok, input string req,
                         input logic [32:0] act, input logic [32:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] exp_header(input logic [1:0] tag, input int n);
        return {8'hA5, 14'd0, tag, 8'(n)};
    endfunction

    function automatic logic [31:0] exp_trailer(input bit err, input int cnt);
        return {8'h5A, err, 7'd0, 16'(cnt)};
    endfunction

    // Source drivers, sink ready and output monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                src_valid = '0;
                fired = '0;
            end else begin
                for (int i = 0; i < N_IN; i++) begin
                    if (fired[i]) begin
                        void'(srcq[i].pop_front());
                        src_valid[i] = 1'b0;
                    end
                    if (!src_valid[i] && srcq[i].size() > 0 && ($urandom % 5) != 0) begin
                        src_valid[i] = 1'b1;
                        src_data[i*32 +: 32] = srcq[i][0][31:0];
                        src_last[i] = srcq[i][0][32];
                    end
                end
            end
            if (rdy_mode == 0)      pkt_ready = 1'b0;
            else if (rdy_mode == 2) pkt_ready = 1'b1;
            else                    pkt_ready = (($urandom % 4) != 0);
            #3;
            if (!rst) begin
                // R12: single source, gated by the sink
                check($countones(src_ready) <= 1 && (src_ready == '0 || pkt_ready),
                      "R12", {32'd0, pkt_ready}, 33'd1);
                // R7: stalled word held
                if (prev_stall) begin
                    check(pkt_valid && {pkt_ctrl, pkt_data} == prev_word, "R7",
                          {pkt_ctrl, pkt_data}, prev_word);
                end
                prev_stall = pkt_valid && !pkt_ready;
                prev_word  = {pkt_ctrl, pkt_data};
                if (pkt_valid && pkt_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R10 R8 unexpected word", {pkt_ctrl, pkt_data}, 33'd0);
                    end else begin
                        check({pkt_ctrl, pkt_data} == exp_q[0], exp_req[0],
                              {pkt_ctrl, pkt_data}, exp_q[0]);
                        void'(exp_q.pop_front());
                        void'(exp_req.pop_front());
                    end
                end
                fired = src_valid & src_ready;
            end else begin
                prev_stall = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired, actual=hang expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    task automatic strobe(input logic [1:0] tag, input logic [31:0] bits);
        @(negedge clk);
        acc_stb  = 1'b1;
        acc_tag  = tag;
        acc_bits = bits;
        @(negedge clk);
        acc_stb  = 1'b0;
    endtask

    task automatic gen_event(input bit force_bad, input int late_src, input string tail_req);
        logic [1:0]  tag;
        logic [31:0] bits;
        logic [32:0] late_words [$];
        int          total;
        int          nbad;
        tag   = 2'($urandom);
        bits  = $urandom;
        total = 0;
        nbad  = 0;
        exp_q.push_back({1'b1, exp_header(tag, evt_model)}); exp_req.push_back("R1 R5 R10");
        exp_q.push_back({1'b0, bits});                       exp_req.push_back("R2");
        for (int i = 0; i < N_IN; i++) begin
            int         len;
            logic [1:0] htag;
            bit         bad;
            len  = 1 + ($urandom % 4);
            bad  = (force_bad && i == 1) || (!force_bad && late_src < 0 && ($urandom % 10) == 0);
            htag = bad ? tag + 2'(1 + ($urandom % 3)) : tag;
            if (bad) nbad++;
            for (int k = 0; k < len; k++) begin
                logic [31:0] w;
                logic [32:0] e;
                w = $urandom;
                if (k == 0) w[1:0] = htag;
                e = {(k == len - 1), w};
                if (i == late_src) late_words.push_back(e);
                else               srcq[i].push_back(e);
                exp_q.push_back({1'b0, w}); exp_req.push_back("R3");
            end
            total += len;
        end
        exp_q.push_back({1'b1, exp_trailer(nbad != 0, total)}); exp_req.push_back(tail_req);
        evt_model++;
        mis_model = (mis_model + nbad > MIS_SAT) ? MIS_SAT : mis_model + nbad;
        while (acc_busy) @(negedge clk);
        strobe(tag, bits);
        if (late_src >= 0) begin
            repeat (40) @(negedge clk);
            foreach (late_words[j]) srcq[late_src].push_back(late_words[j]);
        end
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h1bad5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #3;
        // R11: reset state
        check(!pkt_valid && !acc_busy && mis_count == '0 && src_ready == '0, "R11 reset state",
              {30'd0, pkt_valid, acc_busy, |mis_count}, 33'd0);

        // Directed: clean event, sink always ready
        rdy_mode = 2;
        gen_event(1'b0, -1, "R4");
        wait_drain();

        // Directed: mismatching fragment on source 1
        gen_event(1'b1, 1, "R4 R6");
        wait_drain();
        check(int'(mis_count) == mis_model, "R6 mismatch count", 33'(mis_count), 33'(mis_model));

        // Directed: source 2 empty mid-event
        rdy_mode = 1;
        gen_event(1'b0, 2, "R9 R4");
        wait_drain();

        // Directed: fill the accept queue while the sink stalls
        rdy_mode = 0;
        for (int e = 0; e < ACC_DEPTH; e++) gen_event(1'b0, -1, "R4 R8");
        @(negedge clk);
        check(acc_busy == 1'b1, "R8 busy when full", 33'(acc_busy), 33'd1);
        strobe(2'd3, 32'hDEAD_BEEF);   // refused: no package expected
        check(acc_busy == 1'b1, "R8 busy held", 33'(acc_busy), 33'd1);
        rdy_mode = 1;
        wait_drain();
        check(acc_busy == 1'b0, "R8 busy released", 33'(acc_busy), 33'd0);

        // Random run: event number wraps, mismatch count saturates
        for (int e = 0; e < N_RAND; e++) gen_event(1'b0, -1, "R4 R5");
        wait_drain();
        check(evt_model > 256, "R5 wrap reached", 33'(evt_model), 33'd257);
        check(int'(mis_count) == mis_model, "R6 saturated count", 33'(mis_count), 33'(mis_model));

        // Reset in the middle of an event
        exp_q.push_back({1'b1, exp_header(2'd2, evt_model)}); exp_req.push_back("R1");
        exp_q.push_back({1'b0, 32'h0123_4567});               exp_req.push_back("R2");
        strobe(2'd2, 32'h0123_4567);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < N_IN; i++) srcq[i].delete();
        exp_q.delete();
        exp_req.delete();
        evt_model = 0;
        mis_model = 0;
        rst = 1'b0;
        @(negedge clk);
        #3;
        check(!pkt_valid && !acc_busy && mis_count == '0, "R11 mid-event reset",
              {30'd0, pkt_valid, acc_busy, |mis_count}, 33'd0);
        @(negedge clk);
        gen_event(1'b0, -1, "R4 R11");
        wait_drain();

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule